// File: doc/BRIEF.md
# LPC I/O Cycle Host Engine

This block lets a processor that has no native I/O address space reach legacy ISA-style peripherals over a Low Pin Count bus. Software sees a small word-aligned register window. It sets a byte count, a direction and addressing mode, and a 16-bit port address. For a write it also loads the outgoing bytes into a transmit FIFO. It then sets the launch bit. The engine runs one byte-wide LPC I/O cycle per counted byte. The address either steps up by one after each byte or stays on the same port every time, which suits a streaming data port.

Progress shows in two status bits. One bit says the engine is idle. The other says the last burst ran to completion. When the engine is idle and the completion bit is clear, the burst was aborted. An abort comes from an error handshake from the peripheral or from a wait that runs too long. An abort drops the remaining bytes and empties both FIFOs. Bytes returned by reads collect in a receive FIFO, and software drains it once the burst has completed. One core clock equals one LPC clock.

Top module: `lpc_io_host`

## Requirements
- R1: After reset the status word reads 1 (idle set, completion clear), the frame strobe `lframe_no` is high, `lad_oe_o` is low, and a read of the receive port returns 0xFFFFFFFF.
- R2: Each byte cycle drives, on consecutive clocks: a 0000 start nibble with `lframe_no` low for exactly one clock; a type nibble of 0010 for a write or 0000 for a read; four address nibbles, most significant first; for a write, the data byte low nibble then high nibble. Two turnaround clocks follow, in which the host drives 1111 and then releases the bus. Then come the sync clocks and two more turnaround clocks in which the host does not drive. With an immediate ready sync, one byte cycle takes 13 clocks.
- R3: When command bit 3 is 0, byte n of a burst goes to the programmed address plus n. When command bit 3 is 1, every byte goes to the programmed address.
- R4: Command bit 0 set to 0 selects read. A read cycle samples two data nibbles, low first, in the two clocks after a ready sync, and pushes the byte into the receive FIFO. Reads of offset 0x28 pop bytes in arrival order into bits 7:0. A pop of an empty receive FIFO returns 0xFFFFFFFF.
- R5: Writing 1 to bit 0 of offset 0x00 while idle, with a nonzero length, clears both status bits at once. When the last byte completes, the status word (offset 0x04) reads 3.
- R6: Sync 0000 means ready. Sync 0101 (short wait) and 0110 (long wait) hold the cycle, and up to 256 wait clocks in one cycle are tolerated. A 257th consecutive wait clock aborts the burst.
- R7: A sync code other than ready or wait aborts the burst. So does a wait timeout. No further byte cycle starts, the status reads 1, and both FIFOs are emptied.
- R8: A launch with length 0 starts no bus activity, and the status reads 3 on the next clock.
- R9: While the engine is busy, writes to length, command, address, transmit port and launch have no effect.
- R10: Each FIFO holds 16 bytes, and a push into a full FIFO is dropped. A write cycle whose transmit FIFO is empty sends 0xFF. A length write above 16 is stored as 16.
- R11: Length reads back at 0x10. Command reads back at 0x14, holding only bits 0 and 3. The port address reads back at 0x20 in bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core and LPC clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = register write, 0 = register read |
| addr_i | input | 6 | Byte offset of the register |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, valid while req_i is high and we_i is low |
| lad_i | input | 4 | LAD nibble driven by the peripheral |
| lad_o | output | 4 | LAD nibble driven by the host |
| lad_oe_o | output | 1 | Host drive enable for LAD |
| lframe_no | output | 1 | Frame strobe, active low |

## Verification
Directed bursts exercise the main function in several forms. One is a three-byte write to stepping addresses. Another is a four-byte read on one fixed port, which separates the two address modes and the two type nibbles. A 16-byte fixed write fed by 17 pushes separates correct FIFO depth from overflow. Sync patterns are varied: immediate ready, three short waits, exactly 256 long waits and 257 long waits. These separate tolerance from timeout. An error sync in the middle of a burst shows the early stop and the flush of both FIFOs, and the flush is observed through later empty pops. Launches with length zero and register writes made during a busy burst show the cases where nothing should change.

// File: rtl/lpc_host_pkg.sv
package lpc_host_pkg;

  typedef enum logic [3:0] {
    PH_IDLE, PH_START, PH_CTDIR, PH_ADDR, PH_WDATA,
    PH_TAR1, PH_SYNC, PH_RDATA, PH_TAR2
  } phase_e;

  localparam logic [3:0] NIB_START  = 4'h0;
  localparam logic [3:0] CT_IO_RD   = 4'h0;
  localparam logic [3:0] CT_IO_WR   = 4'h2;
  localparam logic [3:0] NIB_PARK   = 4'hF;
  localparam logic [3:0] SYNC_READY = 4'h0;
  localparam logic [3:0] SYNC_SHORT = 4'h5;
  localparam logic [3:0] SYNC_LONG  = 4'h6;

  // register word index = byte offset / 4
  localparam logic [3:0] RW_START  = 4'd0;
  localparam logic [3:0] RW_STATUS = 4'd1;
  localparam logic [3:0] RW_LEN    = 4'd4;
  localparam logic [3:0] RW_CMD    = 4'd5;
  localparam logic [3:0] RW_ADDR   = 4'd8;
  localparam logic [3:0] RW_WDATA  = 4'd9;
  localparam logic [3:0] RW_RDATA  = 4'd10;

endpackage

// File: rtl/lpc_byte_fifo.sv
module lpc_byte_fifo #(
  parameter int DEPTH = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       flush_i,
  input  logic       push_i,
  input  logic [7:0] din_i,
  input  logic       pop_i,
  output logic [7:0] dout_o,
  output logic       empty_o,
  output logic       full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = empty_o ? 8'hFF : mem[rd_ptr];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem[wr_ptr] <= din_i;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> full_o && $stable(wr_ptr)); // R10
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> empty_o); // R10
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH)); // R10

endmodule

// File: rtl/lpc_cycle_seq.sv
module lpc_cycle_seq
  import lpc_host_pkg::*;
#(
  parameter int MAX_LEN    = 16,
  parameter int WAIT_LIMIT = 256,
  parameter int ADDR_W     = 16
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             go_i,
  input  logic [$clog2(MAX_LEN+1)-1:0]     len_i,
  input  logic                             write_i,
  input  logic                             fixed_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [7:0]                       wbyte_i,
  input  logic [3:0]                       lad_i,
  output logic                             busy_o,
  output logic                             wpop_o,
  output logic                             rpush_o,
  output logic [7:0]                       rbyte_o,
  output logic                             done_o,
  output logic                             fail_o,
  output logic [3:0]                       lad_o,
  output logic                             lad_oe_o,
  output logic                             lframe_no
);
  localparam int LW  = $clog2(MAX_LEN + 1);
  localparam int WW  = $clog2(WAIT_LIMIT + 1);
  localparam int NIB = ADDR_W / 4;
  localparam int IW  = (NIB > 2) ? $clog2(NIB) : 1;

  phase_e            ph;
  logic [IW-1:0]     idx;
  logic [LW-1:0]     left;
  logic [ADDR_W-1:0] cur_addr;
  logic [7:0]        wdat;
  logic [3:0]        lo_nib;
  logic [WW-1:0]     wcnt;
  logic              wr_q, fix_q;
  logic              is_ready, is_wait, timeout, last;

  assign is_ready = (lad_i == SYNC_READY);
  assign is_wait  = (lad_i == SYNC_SHORT) || (lad_i == SYNC_LONG);
  assign timeout  = is_wait && (wcnt == WW'(WAIT_LIMIT));
  assign last     = (left == LW'(1));

  assign busy_o  = (ph != PH_IDLE);
  assign fail_o  = (ph == PH_SYNC) && ((!is_ready && !is_wait) || timeout);
  assign done_o  = (ph == PH_TAR2) && (idx == IW'(1)) && last;
  assign wpop_o  = (ph == PH_START) && wr_q;
  assign rpush_o = (ph == PH_RDATA) && (idx == IW'(1));
  assign rbyte_o = {lad_i, lo_nib};

  always_comb begin
    lad_o     = NIB_PARK;
    lad_oe_o  = 1'b0;
    lframe_no = 1'b1;
    unique case (ph)
      PH_START: begin lframe_no = 1'b0; lad_oe_o = 1'b1; lad_o = NIB_START; end
      PH_CTDIR: begin lad_oe_o = 1'b1; lad_o = wr_q ? CT_IO_WR : CT_IO_RD; end
      PH_ADDR:  begin lad_oe_o = 1'b1; lad_o = cur_addr[4*(NIB-1-int'(idx)) +: 4]; end
      PH_WDATA: begin lad_oe_o = 1'b1; lad_o = (idx == '0) ? wdat[3:0] : wdat[7:4]; end
      PH_TAR1:  lad_oe_o = (idx == '0);
      default:  ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph       <= PH_IDLE;
      idx      <= '0;
      left     <= '0;
      cur_addr <= '0;
      wdat     <= '0;
      lo_nib   <= '0;
      wcnt     <= '0;
      wr_q     <= 1'b0;
      fix_q    <= 1'b0;
    end else begin
      unique case (ph)
        PH_IDLE: if (go_i) begin
          ph       <= PH_START;
          wr_q     <= write_i;
          fix_q    <= fixed_i;
          cur_addr <= addr_i;
          left     <= len_i;
        end
        PH_START: begin
          if (wr_q) wdat <= wbyte_i;
          ph <= PH_CTDIR;
        end
        PH_CTDIR: begin ph <= PH_ADDR; idx <= '0; end
        PH_ADDR: begin
          if (idx == IW'(NIB - 1)) begin
            ph  <= wr_q ? PH_WDATA : PH_TAR1;
            idx <= '0;
          end else idx <= idx + 1'b1;
        end
        PH_WDATA: begin
          if (idx == IW'(1)) begin ph <= PH_TAR1; idx <= '0; end
          else idx <= idx + 1'b1;
        end
        PH_TAR1: begin
          if (idx == IW'(1)) begin ph <= PH_SYNC; idx <= '0; wcnt <= '0; end
          else idx <= idx + 1'b1;
        end
        PH_SYNC: begin
          if (fail_o)        ph <= PH_IDLE;
          else if (is_ready) begin ph <= wr_q ? PH_TAR2 : PH_RDATA; idx <= '0; end
          else               wcnt <= wcnt + 1'b1;
        end
        PH_RDATA: begin
          if (idx == '0) begin lo_nib <= lad_i; idx <= idx + 1'b1; end
          else begin ph <= PH_TAR2; idx <= '0; end
        end
        PH_TAR2: begin
          if (idx == '0) idx <= idx + 1'b1;
          else begin
            idx <= '0;
            if (last) ph <= PH_IDLE;
            else begin
              ph   <= PH_START;
              left <= left - 1'b1;
              if (!fix_q) cur_addr <= cur_addr + 1'b1;
            end
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  AST_FRAME_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lframe_no |=> lframe_no && lad_oe_o); // R2
  AST_WAIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph == PH_SYNC) |-> (wcnt <= WW'(WAIT_LIMIT))); // R6
  AST_FAIL_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> !busy_o && lframe_no); // R7

endmodule

// File: rtl/lpc_io_host.sv
module lpc_io_host
  import lpc_host_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int MAX_LEN    = 16,
  parameter int WAIT_LIMIT = 256,
  parameter int ADDR_W     = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [5:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic [3:0]  lad_i,
  output logic [3:0]  lad_o,
  output logic        lad_oe_o,
  output logic        lframe_no
);
  localparam int LW = $clog2(MAX_LEN + 1);

  logic [LW-1:0]     len_q;
  logic [ADDR_W-1:0] tgt_q;
  logic              dir_wr_q, fixed_q, fin_q;
  logic [3:0]        word;
  logic              wr_hit, rd_hit, cfg_ok, start_hit, go;
  logic              busy, seq_done, seq_fail, wpop, rpush;
  logic [7:0]        rbyte, wf_dout, rf_dout;
  logic              wf_empty, wf_full, rf_empty, rf_full;

  assign word      = addr_i[5:2];
  assign wr_hit    = req_i && we_i && (addr_i[1:0] == 2'b00);
  assign rd_hit    = req_i && !we_i && (addr_i[1:0] == 2'b00);
  assign cfg_ok    = wr_hit && !busy;
  assign start_hit = cfg_ok && (word == RW_START) && wdata_i[0];
  assign go        = start_hit && (len_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q    <= '0;
      tgt_q    <= '0;
      dir_wr_q <= 1'b0;
      fixed_q  <= 1'b0;
      fin_q    <= 1'b0;
    end else begin
      if (cfg_ok && word == RW_LEN)
        len_q <= (wdata_i > 32'(MAX_LEN)) ? LW'(MAX_LEN) : LW'(wdata_i);
      if (cfg_ok && word == RW_CMD) begin
        dir_wr_q <= wdata_i[0];
        fixed_q  <= wdata_i[3];
      end
      if (cfg_ok && word == RW_ADDR) tgt_q <= wdata_i[ADDR_W-1:0];
      if (start_hit)     fin_q <= (len_q == '0);
      else if (seq_done) fin_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_hit) begin
      unique case (word)
        RW_STATUS: rdata_o = {30'd0, fin_q, !busy};
        RW_LEN:    rdata_o = 32'(len_q);
        RW_CMD:    rdata_o = {28'd0, fixed_q, 2'b00, dir_wr_q};
        RW_ADDR:   rdata_o = 32'(tgt_q);
        RW_RDATA:  rdata_o = rf_empty ? '1 : {24'd0, rf_dout};
        default:   rdata_o = '0;
      endcase
    end
  end

  lpc_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (seq_fail),
    .push_i  (cfg_ok && word == RW_WDATA),
    .din_i   (wdata_i[7:0]),
    .pop_i   (wpop),
    .dout_o  (wf_dout),
    .empty_o (wf_empty),
    .full_o  (wf_full)
  );

  lpc_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (seq_fail),
    .push_i  (rpush),
    .din_i   (rbyte),
    .pop_i   (rd_hit && word == RW_RDATA),
    .dout_o  (rf_dout),
    .empty_o (rf_empty),
    .full_o  (rf_full)
  );

  lpc_cycle_seq #(
    .MAX_LEN    (MAX_LEN),
    .WAIT_LIMIT (WAIT_LIMIT),
    .ADDR_W     (ADDR_W)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (go),
    .len_i     (len_q),
    .write_i   (dir_wr_q),
    .fixed_i   (fixed_q),
    .addr_i    (tgt_q),
    .wbyte_i   (wf_dout),
    .lad_i     (lad_i),
    .busy_o    (busy),
    .wpop_o    (wpop),
    .rpush_o   (rpush),
    .rbyte_o   (rbyte),
    .done_o    (seq_done),
    .fail_o    (seq_fail),
    .lad_o     (lad_o),
    .lad_oe_o  (lad_oe_o),
    .lframe_no (lframe_no)
  );

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && wr_hit) |=> $stable(len_q) && $stable(tgt_q) && $stable({dir_wr_q, fixed_q})); // R9
  AST_ZERO_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_hit && len_q == '0) |=> !busy && fin_q && lframe_no); // R8
  AST_ABORT_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_fail |=> rf_empty && wf_empty && !fin_q); // R7
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> busy && !fin_q); // R5
  AST_FULL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wf_full && wf_empty) && !(rf_full && rf_empty)); // R10

endmodule

// File: tb/tb_lpc_io_host.sv
module tb_lpc_io_host;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [3:0]  lad_i = 4'hF, lad_o;
  logic        lad_oe, lframe_n;

  always #5 clk = ~clk;

  lpc_io_host dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .lad_i(lad_i), .lad_o(lad_o),
    .lad_oe_o(lad_oe), .lframe_no(lframe_n)
  );

  int checks = 0, errors = 0, ncyc = 0;
  bit finished = 0;

  int         pb_idx;
  int         pw_waits [16];
  logic [3:0] pw_wcode [16];
  logic [3:0] pw_final [16];
  logic [7:0] rd_src   [16];
  logic [3:0] cap_ct   [16];
  logic [15:0] cap_addr[16];
  logic [7:0] cap_wd   [16];
  bit         cap_bad  [16];
  int         cap_start[16];

  initial forever begin @(posedge clk); ncyc++; end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // peripheral model
  initial forever begin
    @(negedge clk);
    if (rst_n && !lframe_n) begin
      int b;
      logic [15:0] a;
      bit w;
      b = (pb_idx > 15) ? 15 : pb_idx;
      cap_start[b] = ncyc;
      @(negedge clk); cap_ct[b] = lad_o; w = (lad_o == 4'h2);
      a = '0;
      for (int i = 0; i < 4; i++) begin @(negedge clk); a = {a[11:0], lad_o}; end
      cap_addr[b] = a;
      if (w) begin
        @(negedge clk); cap_wd[b][3:0] = lad_o;
        @(negedge clk); cap_wd[b][7:4] = lad_o;
      end
      @(negedge clk); if (!(lad_oe && lad_o == 4'hF)) cap_bad[b] = 1;
      @(negedge clk); if (lad_oe) cap_bad[b] = 1;
      for (int k = 0; k < pw_waits[b]; k++) begin @(negedge clk); lad_i = pw_wcode[b]; end
      @(negedge clk); lad_i = pw_final[b];
      pb_idx = pb_idx + 1;
      if (pw_final[b] == 4'h0) begin
        if (!w) begin
          @(negedge clk); lad_i = rd_src[b][3:0];
          @(negedge clk); lad_i = rd_src[b][7:4];
        end
        @(negedge clk); lad_i = 4'hF; if (lad_oe) cap_bad[b] = 1;
        @(negedge clk); if (lad_oe) cap_bad[b] = 1;
      end else begin
        @(negedge clk); lad_i = 4'hF;
      end
    end
  end

  task automatic clr_periph();
    pb_idx = 0;
    for (int i = 0; i < 16; i++) begin
      pw_waits[i] = 0; pw_wcode[i] = 4'h6; pw_final[i] = 4'h0; rd_src[i] = 8'h00;
      cap_ct[i] = 4'hX; cap_addr[i] = 'x; cap_wd[i] = 'x; cap_bad[i] = 0; cap_start[i] = 0;
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #2 d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic wait_idle(output logic [31:0] s);
    int n = 0;
    do begin bus_rd(6'h04, s); n++; end while (!s[0] && n < 5000);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_rd(6'h04, d); chk("R1 status", d, 32'h1);
    chk("R1 lframe", {31'd0, lframe_n}, 32'h1);
    chk("R1 oe", {31'd0, lad_oe}, 32'h0);
    bus_rd(6'h28, d); chk("R1 rx empty", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    bus_wr(6'h10, 5);          bus_rd(6'h10, d); chk("R11 len", d, 5);
    bus_wr(6'h14, 32'h9);      bus_rd(6'h14, d); chk("R11 cmd", d, 32'h9);
    bus_wr(6'h14, 32'hFF);     bus_rd(6'h14, d); chk("R11 cmd mask", d, 32'h9);
    bus_wr(6'h20, 32'h12345);  bus_rd(6'h20, d); chk("R11 addr", d, 32'h2345);
    bus_wr(6'h10, 20);         bus_rd(6'h10, d); chk("R10 len sat", d, 16);
  endtask

  task automatic t_wr_incr();
    logic [31:0] d;
    clr_periph();
    bus_wr(6'h10, 3); bus_wr(6'h14, 1); bus_wr(6'h20, 16'h02F8);
    bus_wr(6'h24, 8'h11); bus_wr(6'h24, 8'h22); bus_wr(6'h24, 8'h33);
    bus_wr(6'h00, 1);
    bus_rd(6'h04, d); chk("R5 busy status", d, 0);
    wait_idle(d); chk("R5 done status", d, 3);
    chk("R2 frames", pb_idx, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R2 wr type", {28'd0, cap_ct[i]}, 2);
      chk("R3 incr addr", {16'd0, cap_addr[i]}, 32'h02F8 + i);
      chk("R2 wr data", {24'd0, cap_wd[i]}, 32'h11 * (i + 1));
      chk("R2 turnaround", {31'd0, cap_bad[i]}, 0);
    end
    chk("R2 13 clocks", cap_start[1] - cap_start[0], 13);
  endtask

  task automatic t_rd_fixed();
    logic [31:0] d;
    logic [7:0] v [4] = '{8'hA5, 8'h5A, 8'hC3, 8'h3C};
    clr_periph();
    for (int i = 0; i < 4; i++) rd_src[i] = v[i];
    bus_wr(6'h10, 4); bus_wr(6'h14, 8); bus_wr(6'h20, 16'h00E4);
    bus_wr(6'h00, 1);
    wait_idle(d); chk("R5 rd done", d, 3);
    for (int i = 0; i < 4; i++) begin
      chk("R3 fixed addr", {16'd0, cap_addr[i]}, 32'hE4);
      chk("R2 rd type", {28'd0, cap_ct[i]}, 0);
      bus_rd(6'h28, d); chk("R4 rx order", d, {24'd0, v[i]});
    end
    chk("R2 rd 13 clocks", cap_start[2] - cap_start[1], 13);
    bus_rd(6'h28, d); chk("R4 empty pop", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_waits();
    logic [31:0] d;
    clr_periph(); pw_waits[0] = 256; pw_wcode[0] = 4'h6; rd_src[0] = 8'h77;
    bus_wr(6'h10, 1); bus_wr(6'h14, 0); bus_wr(6'h20, 16'h0060); bus_wr(6'h00, 1);
    wait_idle(d); chk("R6 256 waits ok", d, 3);
    bus_rd(6'h28, d); chk("R6 data after wait", d, 32'h77);
    clr_periph(); pw_waits[0] = 3; pw_wcode[0] = 4'h5; rd_src[0] = 8'h9E;
    bus_wr(6'h00, 1);
    wait_idle(d); chk("R6 short wait ok", d, 3);
    bus_rd(6'h28, d); chk("R6 short data", d, 32'h9E);
    clr_periph(); pw_waits[0] = 257; pw_wcode[0] = 4'h6; rd_src[0] = 8'h55;
    bus_wr(6'h00, 1);
    wait_idle(d); chk("R6 timeout", d, 1);
    repeat (8) @(negedge clk);
    bus_rd(6'h28, d); chk("R6 no data on timeout", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_error();
    logic [31:0] d;
    clr_periph(); pw_final[1] = 4'hA;
    bus_wr(6'h10, 4); bus_wr(6'h14, 1); bus_wr(6'h20, 16'h0080);
    for (int i = 0; i < 4; i++) bus_wr(6'h24, 8'hD0 + i);
    bus_wr(6'h00, 1);
    wait_idle(d); chk("R7 abort status", d, 1);
    repeat (20) @(negedge clk);
    chk("R7 no further cycles", pb_idx, 2);
    clr_periph();
    bus_wr(6'h10, 1); bus_wr(6'h00, 1);
    wait_idle(d); chk("R7 tx status", d, 3);
    chk("R7 tx flushed", {24'd0, cap_wd[0]}, 32'hFF);
    clr_periph(); rd_src[0] = 8'h11; rd_src[1] = 8'h22; pw_final[2] = 4'hA;
    bus_wr(6'h10, 3); bus_wr(6'h14, 0); bus_wr(6'h00, 1);
    wait_idle(d); chk("R7 rd abort", d, 1);
    bus_rd(6'h28, d); chk("R7 rx flushed", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_zero();
    logic [31:0] d;
    clr_periph();
    bus_wr(6'h10, 0); bus_wr(6'h00, 1);
    bus_rd(6'h04, d); chk("R8 zero len status", d, 3);
    repeat (20) @(negedge clk);
    chk("R8 no frames", pb_idx, 0);
  endtask

  task automatic t_busy();
    logic [31:0] d;
    clr_periph(); pw_waits[0] = 60; rd_src[0] = 8'h42;
    bus_wr(6'h10, 1); bus_wr(6'h14, 0); bus_wr(6'h20, 16'h0100); bus_wr(6'h00, 1);
    bus_wr(6'h10, 7); bus_wr(6'h14, 1); bus_wr(6'h20, 16'h0200);
    bus_wr(6'h24, 8'h99); bus_wr(6'h00, 1);
    wait_idle(d); chk("R9 status", d, 3);
    repeat (20) @(negedge clk);
    chk("R9 one burst", pb_idx, 1);
    bus_rd(6'h10, d); chk("R9 len kept", d, 1);
    bus_rd(6'h14, d); chk("R9 cmd kept", d, 0);
    bus_rd(6'h20, d); chk("R9 addr kept", d, 32'h100);
    bus_rd(6'h28, d); chk("R9 rx data", d, 32'h42);
    clr_periph();
    bus_wr(6'h14, 1); bus_wr(6'h00, 1);
    wait_idle(d);
    chk("R9 tx push ignored", {24'd0, cap_wd[0]}, 32'hFF);
  endtask

  task automatic t_full();
    logic [31:0] d;
    clr_periph();
    bus_wr(6'h10, 16); bus_wr(6'h14, 9); bus_wr(6'h20, 16'h03F8);
    for (int i = 0; i < 17; i++) bus_wr(6'h24, i + 1);
    bus_wr(6'h00, 1);
    wait_idle(d); chk("R10 full burst", d, 3);
    chk("R10 frames", pb_idx, 16);
    for (int i = 0; i < 16; i++) chk("R10 fifo byte", {24'd0, cap_wd[i]}, i + 1);
    chk("R3 fixed last", {16'd0, cap_addr[15]}, 32'h03F8);
    clr_periph();
    bus_wr(6'h10, 1); bus_wr(6'h00, 1);
    wait_idle(d);
    chk("R10 overflow dropped", {24'd0, cap_wd[0]}, 32'hFF);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R5 actual=hung expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clr_periph();
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_wr_incr();
    t_rd_fixed();
    t_waits();
    t_error();
    t_zero();
    t_busy();
    t_full();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule